// File: doc/BRIEF.md
# Single-Byte Serial Register Window

This block is a bus-slave register window that links a processor bus to a byte-wide character channel. Software sends a character by writing it to a transmit word. It fetches a received character by reading a receive word. A status word reports whether a received byte is waiting and whether the transmitter can take another byte. Each direction holds exactly one byte. There is no queue.

Both character channels are valid/ready streams. The receive side keeps at most one byte. While that byte has not been read, the block holds its ready output low toward the incoming stream, so a pending byte is never overwritten and no overrun can occur. A read of the receive word returns the byte and frees the holder in the same access. The transmit side is a single output register. A write to the transmit word is accepted only while that register is empty. Otherwise the write is dropped.

Bus accesses are whole 32-bit words. The byte address is shifted right by two to select a word. The window is 0x18 bytes long. Read data appears one cycle after the access by default. The `READ_LATENCY` parameter can select a combinational read path instead.

Top module: `byte_uart_regs`

## Requirements
- R1: After reset the receive holder is zero, the status word reads 0x0000_0002, `rx_ready` is high and `tx_valid` is low.
- R2: The word is selected by byte address bits [4:2]: word 0 (byte 0x00) is transmit data, which is write-only; word 1 (0x04) is receive data, which is read-only; word 2 (0x08) is status. Address bits [1:0] are ignored.
- R3: An access with `bus_be` other than 4'b1111 has no effect and reads zero.
- R4: Words 3 to 5 and addresses at or above 0x18 read zero, and writes to them change nothing. A read of the transmit word also returns zero.
- R5: With `READ_LATENCY` = 1, `bus_rdata` carries the read value in the cycle after the access, and it is zero in every cycle that follows a cycle without a read.
- R6: The status word has bit 0 set when a received byte is pending and bit 1 set when the transmit register is empty. All higher bits are zero.
- R7: When `rx_valid` and `rx_ready` are both high at a clock edge, `rx_data` is stored, status bit 0 sets and `rx_ready` drops from the next cycle.
- R8: While a byte is pending, `rx_ready` stays low and the stored byte is not replaced, however long `rx_valid` is held.
- R9: A read of the receive word returns the stored byte in bits [7:0] and clears status bit 0. A read while nothing is pending returns the last stored byte and leaves bit 0 clear.
- R10: A write to the transmit word while status bit 1 is set drives `wdata[7:0]` on `tx_data` with `tx_valid` high from the next cycle. `tx_data` holds steady until `tx_ready` is seen, and `tx_valid` drops after that handshake.
- R11: A write to the transmit word while `tx_valid` is high is dropped.
- R12: Writes to the status word have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte address within the window |
| bus_be | input | BUS_W/8 (4) | Byte enables, all must be set |
| bus_wdata | input | BUS_W (32) | Write data |
| bus_rdata | output | BUS_W (32) | Read data |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | CHAR_W (8) | Incoming byte |
| rx_ready | output | 1 | Block can take a byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_data | output | CHAR_W (8) | Outgoing byte |
| tx_ready | input | 1 | Sink takes the outgoing byte |

## Verification
The assertions check the stream rules on every cycle. A capture must drop `rx_ready`, and `rx_ready` must stay low until a receive-word read. An outgoing byte must stay stable until the sink accepts it. The assertions also check the zero read data returned for idle cycles, partial-width accesses and reserved words, and the zero upper bits of the status word. Only the bench scenarios can show which byte value is returned and that the stale byte is returned on an empty read. The same is true of dropped transmit writes, status writes that change nothing, and the state right after a mid-run reset.

// File: rtl/byte_uart_pkg.sv
package byte_uart_pkg;

   // Word indices inside the window. Software depends on these positions.
   localparam int unsigned TX_WORD   = 0;
   localparam int unsigned RX_WORD   = 1;
   localparam int unsigned STAT_WORD = 2;

   // Status bit positions
   localparam int unsigned ST_RX_FULL = 0;
   localparam int unsigned ST_TX_IDLE = 1;
   localparam int unsigned ST_BITS    = 2;

   // One decoded bus access
   typedef struct packed {
      logic tx_wr;
      logic rx_rd;
      logic stat_rd;
   } acc_t;

endpackage

// File: rtl/buart_decode.sv
module buart_decode
   import byte_uart_pkg::*;
#(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned BE_W      = 4,
   parameter int unsigned WIN_BYTES = 24
) (
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BE_W-1:0]   be,
   output acc_t              acc
);
   localparam int unsigned WORD_AW = ADDR_W - 2;
   localparam logic [ADDR_W-1:0] WIN_LAST = ADDR_W'(WIN_BYTES - 1);

   logic [WORD_AW-1:0] word;
   logic               in_win;
   logic               ok;
   logic               unused_addr_lo;

   assign word           = addr[ADDR_W-1:2];
   assign unused_addr_lo = ^addr[1:0];
   assign in_win         = addr <= WIN_LAST;
   assign ok             = sel && (&be) && in_win;

   always_comb begin
      acc         = '0;
      acc.tx_wr   = ok &&  wr && (word == WORD_AW'(TX_WORD));
      acc.rx_rd   = ok && !wr && (word == WORD_AW'(RX_WORD));
      acc.stat_rd = ok && !wr && (word == WORD_AW'(STAT_WORD));
   end

endmodule

// File: rtl/buart_rx_hold.sv
module buart_rx_hold #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CHAR_W-1:0] in_data,
   output logic              in_ready,
   input  logic              take,
   output logic              full,
   output logic [CHAR_W-1:0] held
);
   logic capture;

   assign in_ready = !full;
   assign capture  = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         held <= '0;
      end else begin
         if (capture) begin
            full <= 1'b1;
            held <= in_data;
         end else if (take) begin
            full <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/buart_tx_stage.sv
module buart_tx_stage #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CHAR_W-1:0] load_data,
   output logic              out_valid,
   output logic [CHAR_W-1:0] out_data,
   input  logic              out_ready,
   output logic              idle
);
   assign idle = !out_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         if (out_valid) begin
            if (out_ready) out_valid <= 1'b0;
         end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
         end
      end
   end

endmodule

// File: rtl/byte_uart_regs.sv
module byte_uart_regs
   import byte_uart_pkg::*;
#(
   parameter int unsigned BUS_W        = 32,
   parameter int unsigned CHAR_W       = 8,
   parameter int unsigned ADDR_W       = 5,
   parameter int unsigned WIN_BYTES    = 24,
   parameter int unsigned READ_LATENCY = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [BUS_W/8-1:0]   bus_be,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   input  logic                 rx_valid,
   input  logic [CHAR_W-1:0]    rx_data,
   output logic                 rx_ready,
   output logic                 tx_valid,
   output logic [CHAR_W-1:0]    tx_data,
   input  logic                 tx_ready
);
   localparam int unsigned BE_W = BUS_W / 8;

   // Elaboration-time parameter checks
   if (BUS_W % 8 != 0) begin : g_bad_bus
      $error("BUS_W must be a whole number of bytes");
   end
   if (CHAR_W < 1 || CHAR_W > BUS_W) begin : g_bad_char
      $error("CHAR_W must lie in 1..BUS_W");
   end
   if (ST_BITS > BUS_W) begin : g_bad_stat
      $error("status field does not fit in BUS_W");
   end
   if (ADDR_W < 3 || WIN_BYTES > (1 << ADDR_W) || WIN_BYTES < 4 * (STAT_WORD + 1)) begin : g_bad_win
      $error("window size does not fit ADDR_W or misses the status word");
   end
   if (READ_LATENCY > 1) begin : g_bad_lat
      $error("READ_LATENCY must be 0 or 1");
   end

   acc_t              acc;
   logic              rx_full;
   logic [CHAR_W-1:0] rx_held;
   logic              tx_idle;
   logic [BUS_W-1:0]  rd_val;
   logic              unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata;

   buart_decode #(
      .ADDR_W    (ADDR_W),
      .BE_W      (BE_W),
      .WIN_BYTES (WIN_BYTES)
   ) u_dec (
      .sel  (bus_sel),
      .wr   (bus_wr),
      .addr (bus_addr),
      .be   (bus_be),
      .acc  (acc)
   );

   buart_rx_hold #(.CHAR_W(CHAR_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (rx_valid),
      .in_data  (rx_data),
      .in_ready (rx_ready),
      .take     (acc.rx_rd),
      .full     (rx_full),
      .held     (rx_held)
   );

   buart_tx_stage #(.CHAR_W(CHAR_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (acc.tx_wr),
      .load_data (bus_wdata[CHAR_W-1:0]),
      .out_valid (tx_valid),
      .out_data  (tx_data),
      .out_ready (tx_ready),
      .idle      (tx_idle)
   );

   always_comb begin
      rd_val = '0;
      if (acc.stat_rd) begin
         rd_val[ST_RX_FULL] = rx_full;
         rd_val[ST_TX_IDLE] = tx_idle;
      end else if (acc.rx_rd) begin
         rd_val[CHAR_W-1:0] = rx_held;
      end
   end

   if (READ_LATENCY == 1) begin : g_rd_reg
      logic [BUS_W-1:0] rdata_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata_q <= '0;
         else        rdata_q <= rd_val;
      end
      assign bus_rdata = rdata_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_val;
   end

endmodule

// File: rtl/byte_uart_regs_chk.sv
module byte_uart_regs_chk #(
   parameter int unsigned BUS_W        = 32,
   parameter int unsigned CHAR_W       = 8,
   parameter int unsigned ADDR_W       = 5,
   parameter int unsigned WIN_BYTES    = 24,
   parameter int unsigned READ_LATENCY = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [BUS_W/8-1:0] bus_be,
   input logic [BUS_W-1:0]   bus_rdata,
   input logic               rx_valid,
   input logic               rx_ready,
   input logic               tx_valid,
   input logic [CHAR_W-1:0]  tx_data,
   input logic               tx_ready
);
   logic [ADDR_W-3:0] word;
   logic              full_w;
   logic              in_win;
   logic              rx_read;
   logic              reserved_rd;
   logic              stat_rd;

   assign word        = bus_addr[ADDR_W-1:2];
   assign full_w      = &bus_be;
   assign in_win      = int'(bus_addr) < int'(WIN_BYTES);
   assign rx_read     = bus_sel && !bus_wr && full_w && in_win && (int'(word) == 1);
   assign stat_rd     = bus_sel && !bus_wr && full_w && in_win && (int'(word) == 2);
   assign reserved_rd = bus_sel && !bus_wr && (int'(word) >= 3);

   // R7: a capture drops rx_ready on the next cycle
   assert_capture_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_ready |=> !rx_ready);

   // R8: a pending byte keeps the input held off until a receive-word read
   assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ready && !rx_read |=> !rx_ready);

   // R10: the outgoing byte is stable until the sink takes it
   assert_tx_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

   // R10: a handshake empties the transmit register
   assert_tx_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready |=> !tx_valid);

   if (READ_LATENCY == 1) begin : g_lat1
      // R5: no read means zero read data on the next cycle
      assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !bus_sel |=> bus_rdata == '0);

      // R3: partial-width accesses read zero
      assert_partial_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
         bus_sel && !full_w |=> bus_rdata == '0);

      // R4: reserved words and out-of-window addresses read zero
      assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
         reserved_rd |=> bus_rdata == '0);

      // R6: status upper bits are zero
      assert_status_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
         stat_rd |=> bus_rdata[BUS_W-1:2] == '0);
   end

endmodule

bind byte_uart_regs byte_uart_regs_chk #(
   .BUS_W        (BUS_W),
   .CHAR_W       (CHAR_W),
   .ADDR_W       (ADDR_W),
   .WIN_BYTES    (WIN_BYTES),
   .READ_LATENCY (READ_LATENCY)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_be    (bus_be),
   .bus_rdata (bus_rdata),
   .rx_valid  (rx_valid),
   .rx_ready  (rx_ready),
   .tx_valid  (tx_valid),
   .tx_data   (tx_data),
   .tx_ready  (tx_ready)
);

// File: tb/byte_uart_regs_tb_top.sv
module byte_uart_regs_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_ready = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   byte_uart_regs dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_be    (bus_be),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .rx_valid  (rx_valid),
      .rx_data   (rx_data),
      .rx_ready  (rx_ready),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .tx_ready  (tx_ready)
   );

   typedef struct packed {
      logic        wr;
      logic [4:0]  addr;
      logic [3:0]  be;
      logic [31:0] wdata;
      logic [31:0] exp;
      logic [7:0]  req;
   } vec_t;

   // Register-level vectors, walked with both streams quiet and tx_ready low.
   // Tags: R1 reset, R2 decode, R3 width, R4 reserved, R10/R11 transmit, R12 status write.
   localparam vec_t VECS [17] = '{
      '{1'b0, 5'h08, 4'hF, 32'h0,         32'h2, 8'd1 },  // R1 status
      '{1'b0, 5'h04, 4'hF, 32'h0,         32'h0, 8'd1 },  // R1 holder zero
      '{1'b0, 5'h0C, 4'hF, 32'h0,         32'h0, 8'd4 },  // R4 word 3
      '{1'b0, 5'h14, 4'hF, 32'h0,         32'h0, 8'd4 },  // R4 word 5
      '{1'b0, 5'h1C, 4'hF, 32'h0,         32'h0, 8'd4 },  // R4 beyond window
      '{1'b1, 5'h08, 4'hF, 32'hFFFF_FFFF, 32'h0, 8'd12},  // R12 status write
      '{1'b0, 5'h08, 4'hF, 32'h0,         32'h2, 8'd12},  // R12 unchanged
      '{1'b0, 5'h0A, 4'hF, 32'h0,         32'h2, 8'd2 },  // R2 low bits ignored
      '{1'b0, 5'h08, 4'h7, 32'h0,         32'h0, 8'd3 },  // R3 partial read
      '{1'b1, 5'h00, 4'h7, 32'h0000_00A5, 32'h0, 8'd3 },  // R3 partial write
      '{1'b0, 5'h08, 4'hF, 32'h0,         32'h2, 8'd3 },  // R3 tx still idle
      '{1'b1, 5'h01, 4'hF, 32'h1234_5696, 32'h0, 8'd10},  // R10 load 0x96
      '{1'b0, 5'h08, 4'hF, 32'h0,         32'h0, 8'd10},  // R10 tx busy
      '{1'b1, 5'h00, 4'hF, 32'h0000_0011, 32'h0, 8'd11},  // R11 dropped
      '{1'b1, 5'h0C, 4'hF, 32'h0000_0077, 32'h0, 8'd4 },  // R4 write ignored
      '{1'b0, 5'h00, 4'hF, 32'h0,         32'h0, 8'd4 },  // R4 tx word reads 0
      '{1'b0, 5'h0C, 4'hF, 32'h0,         32'h0, 8'd4 }   // R4 still zero
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [4:0] addr, input logic [3:0] be,
                         input logic [31:0] wd, output logic [31:0] rd);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_be = be; bus_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      rd = bus_rdata;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
   endtask

   task automatic push_rx(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b;
      @(posedge clk);
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
      $finish;
   end

   initial begin
      logic [31:0] rd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
      check("R1 tx_valid", {31'b0, tx_valid}, 32'h0);

      for (int i = 0; i < 17; i++) begin
         access(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].wdata, rd);
         if (!VECS[i].wr) begin
            checks++;
            if (rd !== VECS[i].exp) begin
               fails++;
               $display("FAIL R%0d vector %0d: actual=0x%08h expected=0x%08h",
                        VECS[i].req, i, rd, VECS[i].exp);
            end
         end
      end

      // R10 R11: first byte on the stream, later write dropped
      check("R10 tx_valid", {31'b0, tx_valid}, 32'h1);
      check("R11 tx_data", {24'b0, tx_data}, 32'h96);
      @(negedge clk); tx_ready = 1'b1;
      @(posedge clk);
      @(negedge clk); tx_ready = 1'b0;
      check("R10 drain", {31'b0, tx_valid}, 32'h0);
      access(1'b0, 5'h08, 4'hF, 32'h0, rd);
      check("R6 tx idle", rd, 32'h2);
      @(posedge clk); @(negedge clk);
      check("R5 idle rdata", bus_rdata, 32'h0);

      // R7 capture
      push_rx(8'hC3);
      check("R7 rx_ready low", {31'b0, rx_ready}, 32'h0);
      access(1'b0, 5'h08, 4'hF, 32'h0, rd);
      check("R7 status", rd, 32'h3);

      // R8 hold-off with a long offer
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'h5E;
      repeat (3) begin
         @(posedge clk); @(negedge clk);
         check("R8 rx_ready", {31'b0, rx_ready}, 32'h0);
      end
      rx_valid = 1'b0;

      // R9 read returns byte and clears flag
      access(1'b0, 5'h04, 4'hF, 32'h0, rd);
      check("R9 rx byte", rd, 32'hC3);
      check("R9 rx_ready", {31'b0, rx_ready}, 32'h1);
      access(1'b0, 5'h08, 4'hF, 32'h0, rd);
      check("R9 flag clear", rd, 32'h2);
      access(1'b0, 5'h04, 4'hF, 32'h0, rd);
      check("R9 stale byte", rd, 32'hC3);
      access(1'b0, 5'h08, 4'hF, 32'h0, rd);
      check("R9 still clear", rd, 32'h2);

      // R12 with a pending byte
      push_rx(8'h5E);
      access(1'b1, 5'h08, 4'hF, 32'h0, rd);
      access(1'b0, 5'h08, 4'hF, 32'h0, rd);
      check("R12 status kept", rd, 32'h3);
      access(1'b0, 5'h04, 4'hF, 32'h0, rd);
      check("R8 byte kept", rd, 32'h5E);

      // R1 mid-run reset with byte pending and tx busy
      push_rx(8'h7A);
      access(1'b1, 5'h00, 4'hF, 32'h0000_0042, rd);
      check("R10 busy before reset", {31'b0, tx_valid}, 32'h1);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check("R1 tx_valid after reset", {31'b0, tx_valid}, 32'h0);
      check("R1 rx_ready after reset", {31'b0, rx_ready}, 32'h1);
      access(1'b0, 5'h08, 4'hF, 32'h0, rd);
      check("R1 status after reset", rd, 32'h2);
      access(1'b0, 5'h04, 4'hF, 32'h0, rd);
      check("R1 holder after reset", rd, 32'h0);

      report();
      $finish;
   end

endmodule